// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation miss by reading a two-level page table in memory. A miss request brings a 32-bit virtual address, and the base of the current first-level table comes in at the same time. The walker then issues word reads on a valid/ready memory port, with never more than one read in flight. It finishes with either a refill entry for the translation buffer or a page-fault indication. A first-level entry can map a large page directly, and in that case the walk stops after a single read.

The virtual address is split into three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the page offset. Every table entry is one 32-bit word, laid out as follows:

| Bits | Meaning |
|------|---------|
| 0 | present |
| 1 | terminal (the entry is a mapping, not a pointer) |
| 4:2 | three permission/usage flags |
| 31:12 | physical page number, or the base of the next table |

The walker reads the entry, decides from the present and terminal bits what to do next, and copies the permission and page-number fields into the refill without altering them.

Top module: `pt_walker2`

## Requirements
- R1: After reset the walker accepts misses (`miss_ready`=1), issues no memory read, and raises neither `refill_valid` nor `fault_valid`.
- R2: The first read after a miss is accepted goes to `root_base + 4*vaddr[31:22]`, where `root_base` is the value sampled when the miss was accepted.
- R3: When the first-level entry is present and not terminal, the second read goes to `{entry[31:12],12'h000} + 4*vaddr[21:12]`.
- R4: An entry is decoded as follows: bit 0 is present, bit 1 is terminal, bits 4:2 are the permission flags, and bits 31:12 are the page number or the next table base.
- R5: A present, terminal first-level entry ends the walk after exactly one read. The refill then has `refill_large`=1, `refill_ppn`=entry[31:12] and `refill_perm`=entry[4:2].
- R6: A present, terminal second-level entry ends the walk after exactly two reads. The refill then has `refill_large`=0, `refill_ppn`=entry[31:12] and `refill_perm`=entry[4:2].
- R7: A first-level entry that is not present produces a fault with `fault_level`=0 after one read. A second-level entry that is not present produces a fault with `fault_level`=1 after two reads.
- R8: A second-level entry that is present but not terminal produces a fault with `fault_level`=1.
- R9: At most one read is outstanding at a time. While `mem_req_valid` is not yet accepted, it stays high and `mem_req_addr` stays stable.
- R10: While a walk is in progress, `miss_ready` is 0, and any `miss_valid` or change of `miss_vaddr` has no effect on the walk.
- R11: `refill_valid` and `fault_valid` are single-cycle pulses and are never high together. `refill_vpn` and `fault_vaddr` carry the accepted miss address (its bits 31:12 for the refill, the full address for the fault).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_base | input | 32 | Base of the first-level table |
| mem_req_valid | output | 1 | Word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word returned |
| refill_valid | output | 1 | One-cycle pulse: translation found |
| refill_vpn | output | 20 | Virtual page number of the miss |
| refill_ppn | output | 20 | Physical page number from the entry |
| refill_perm | output | 3 | Permission flags from the entry |
| refill_large | output | 1 | Translation maps a large page |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | Table level of the fault (0 first, 1 second) |
| fault_vaddr | output | 32 | Virtual address that faulted |

## Verification
A miss is accepted on the clock edge where `miss_valid` and `miss_ready` are both high, and the first read is offered in the cycle that follows. A memory response accepted at an edge makes `refill_valid` or `fault_valid` visible in the next cycle, for exactly one cycle, and `miss_ready` is high again in that same cycle. The bench drives and samples on falling edges only. It waits for the result pulse, then checks in the following cycle that the pulse has dropped. The memory model varies both the request-acceptance stall and the response latency. Because of this the bench counts the reads actually accepted, and does not count cycles.

// File: rtl/ptw_pkg.sv
// Package: shared constants and state encoding for the two-level walker.
// Assumes one table entry is a single machine word whose low bits hold flags.
package ptw_pkg;
    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_TERM_BIT    = 1;
    localparam int PTE_PERM_LSB    = 2;
    localparam int PTE_PERM_W      = 3;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4
    } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
// Module: forms the byte address of the table entry for the current level.
// Assumes table bases are byte addresses and entries are 2**ENTRY_SHIFT bytes.
module ptw_entry_addr #(
    parameter int VA_W        = 32,
    parameter int IDX_W       = 10,
    parameter int OFF_W       = 12,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [VA_W-1:0]       root_q,
    input  logic [VA_W-OFF_W-1:0] next_base_pn,
    input  logic [VA_W-1:0]       vaddr_q,
    input  logic                  second_level,
    output logic [VA_W-1:0]       entry_addr
);
    localparam int L1_LSB = OFF_W + IDX_W;
    localparam int L2_LSB = OFF_W;

    logic [IDX_W-1:0] idx;
    logic [VA_W-1:0]  base;

    // Select the table base and the index field for the level in progress.
    always_comb begin
        if (second_level) begin
            base = {next_base_pn, {OFF_W{1'b0}}};
            idx  = vaddr_q[L2_LSB +: IDX_W];
        end else begin
            base = root_q;
            idx  = vaddr_q[L1_LSB +: IDX_W];
        end
        entry_addr = base + (VA_W'(idx) << ENTRY_SHIFT);
    end
endmodule

// File: rtl/ptw_entry_decode.sv
// Module: splits a returned table entry into its flag and page fields.
// Assumes the entry is as wide as an address and the page field sits above OFF_W.
module ptw_entry_decode #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]                 entry,
    output logic                            present,
    output logic                            terminal,
    output logic [ptw_pkg::PTE_PERM_W-1:0]  perm,
    output logic [VA_W-OFF_W-1:0]           page
);
    import ptw_pkg::*;

    // Pure field extraction; no state.
    always_comb begin
        present  = entry[PTE_PRESENT_BIT];
        terminal = entry[PTE_TERM_BIT];
        perm     = entry[PTE_PERM_LSB +: PTE_PERM_W];
        page     = entry[VA_W-1:OFF_W];
    end
endmodule

// File: rtl/ptw_walk_fsm.sv
// Module: sequences the walk: latches the miss, issues one read per level,
// and ends with a one-cycle refill or fault pulse.
// Assumes memory answers each accepted read exactly once, in order.
module ptw_walk_fsm #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            miss_valid,
    output logic                            miss_ready,
    input  logic [VA_W-1:0]                 miss_vaddr,
    input  logic [VA_W-1:0]                 root_base,
    output logic                            mem_req_valid,
    input  logic                            mem_req_ready,
    input  logic [VA_W-1:0]                 mem_req_addr,
    input  logic                            mem_rsp_valid,
    input  logic                            ent_present,
    input  logic                            ent_terminal,
    input  logic [ptw_pkg::PTE_PERM_W-1:0]  ent_perm,
    input  logic [VA_W-OFF_W-1:0]           ent_page,
    output logic [VA_W-1:0]                 root_q,
    output logic [VA_W-1:0]                 vaddr_q,
    output logic [VA_W-OFF_W-1:0]           next_base_pn,
    output logic                            second_level,
    output logic                            refill_valid,
    output logic [VA_W-OFF_W-1:0]           refill_ppn,
    output logic [ptw_pkg::PTE_PERM_W-1:0]  refill_perm,
    output logic                            refill_large,
    output logic                            fault_valid,
    output logic                            fault_level
);
    import ptw_pkg::*;

    walk_state_e state;

    // Handshake outputs decoded from the current state.
    always_comb begin
        miss_ready    = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        second_level  = (state == ST_L2_REQ);
    end

    // Walk sequencing, captured miss context and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            root_q       <= '0;
            vaddr_q      <= '0;
            next_base_pn <= '0;
            refill_valid <= 1'b0;
            refill_ppn   <= '0;
            refill_perm  <= '0;
            refill_large <= 1'b0;
            fault_valid  <= 1'b0;
            fault_level  <= 1'b0;
        end else begin
            refill_valid <= 1'b0;
            fault_valid  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (miss_valid) begin
                        vaddr_q <= miss_vaddr;
                        root_q  <= root_base;
                        state   <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            fault_valid <= 1'b1;
                            fault_level <= 1'b0;
                            state       <= ST_IDLE;
                        end else if (ent_terminal) begin
                            refill_valid <= 1'b1;
                            refill_ppn   <= ent_page;
                            refill_perm  <= ent_perm;
                            refill_large <= 1'b1;
                            state        <= ST_IDLE;
                        end else begin
                            next_base_pn <= ent_page;
                            state        <= ST_L2_REQ;
                        end
                    end
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present || !ent_terminal) begin
                            fault_valid <= 1'b1;
                            fault_level <= 1'b1;
                        end else begin
                            refill_valid <= 1'b1;
                            refill_ppn   <= ent_page;
                            refill_perm  <= ent_perm;
                            refill_large <= 1'b0;
                        end
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
    AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault_valid) |-> (!mem_req_valid && miss_ready)); // R9
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (mem_req_valid && !miss_ready)); // R10
    AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> !refill_valid); // R11
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid); // R11
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && fault_valid)); // R11
    AST_LARGE_FROM_L1: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid && refill_large) |-> ($past(state) == ST_L1_WAIT)); // R5
endmodule

// File: rtl/pt_walker2.sv
// Module: top of the two-level table walker; connects the sequencer, the
// entry-address former and the entry decoder.
// Assumes one read outstanding and in-order word responses.
module pt_walker2 #(
    parameter int IDX_W       = 10,
    parameter int OFF_W       = 12,
    parameter int ENTRY_SHIFT = 2,
    localparam int VA_W       = 2 * IDX_W + OFF_W,
    localparam int PN_W       = VA_W - OFF_W,
    localparam int PERM_W     = ptw_pkg::PTE_PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [VA_W-1:0]   root_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              refill_valid,
    output logic [PN_W-1:0]   refill_vpn,
    output logic [PN_W-1:0]   refill_ppn,
    output logic [PERM_W-1:0] refill_perm,
    output logic              refill_large,
    output logic              fault_valid,
    output logic              fault_level,
    output logic [VA_W-1:0]   fault_vaddr
);
    logic [VA_W-1:0]   root_q;
    logic [VA_W-1:0]   vaddr_q;
    logic [PN_W-1:0]   next_base_pn;
    logic              second_level;
    logic              ent_present;
    logic              ent_terminal;
    logic [PERM_W-1:0] ent_perm;
    logic [PN_W-1:0]   ent_page;

    ptw_walk_fsm #(.VA_W(VA_W), .OFF_W(OFF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vaddr(miss_vaddr), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .ent_present(ent_present), .ent_terminal(ent_terminal),
        .ent_perm(ent_perm), .ent_page(ent_page),
        .root_q(root_q), .vaddr_q(vaddr_q), .next_base_pn(next_base_pn),
        .second_level(second_level),
        .refill_valid(refill_valid), .refill_ppn(refill_ppn),
        .refill_perm(refill_perm), .refill_large(refill_large),
        .fault_valid(fault_valid), .fault_level(fault_level)
    );

    ptw_entry_addr #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
        .root_q(root_q), .next_base_pn(next_base_pn), .vaddr_q(vaddr_q),
        .second_level(second_level), .entry_addr(mem_req_addr)
    );

    ptw_entry_decode #(.VA_W(VA_W), .OFF_W(OFF_W)) u_dec (
        .entry(mem_rsp_data), .present(ent_present), .terminal(ent_terminal),
        .perm(ent_perm), .page(ent_page)
    );

    // The miss context doubles as the reported page number and fault address.
    always_comb begin
        refill_vpn  = vaddr_q[VA_W-1:OFF_W];
        fault_vaddr = vaddr_q;
    end
endmodule

// File: tb/sim_pt_walker2.sv
// Bench: sweeps every first-level index and every second-level index of one
// table against an arithmetic memory image, with varied stalls and latency.
module sim_pt_walker2;
    localparam logic [31:0] ROOT   = 32'h0040_0000;
    localparam logic [31:0] L2BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [31:0] root_base = ROOT;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [19:0] refill_ppn;
    logic [2:0]  refill_perm;
    logic        refill_large;
    logic        fault_valid;
    logic        fault_level;
    logic [31:0] fault_vaddr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nreads = 0;
    bit pend = 1'b0;
    int dly = 0;
    logic [31:0] paddr = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pt_walker2 u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vaddr(miss_vaddr), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_perm(refill_perm),
        .refill_large(refill_large), .fault_valid(fault_valid),
        .fault_level(fault_level), .fault_vaddr(fault_vaddr)
    );

    // Arithmetic memory image; unmapped addresses read as zero (not present).
    function automatic logic [31:0] pte_at(input logic [31:0] a);
        logic [31:0] i;
        logic [31:0] j;
        if (a >= ROOT && a < ROOT + 32'h1000) begin
            i = (a - ROOT) >> 2;
            case (i % 4)
                0: return {20'(i * 13 + 5), 7'd0, 3'(i), 1'b0, 1'b0};
                1: return {20'h80000 | 20'(i), 7'd0, 3'(i % 8), 1'b1, 1'b1};
                default: return {20'((L2BASE >> 12) + i), 7'd0, 3'(i + 1), 1'b0, 1'b1};
            endcase
        end else if (a >= L2BASE && a < L2BASE + 32'h0040_0000) begin
            i = (a - L2BASE) >> 12;
            j = (a >> 2) & 32'h3FF;
            case (j % 3)
                0: return {20'(j * 3), 7'd0, 3'(j), 1'b1, 1'b0};
                1: return {20'(((i << 10) ^ j) ^ 32'h30000), 7'd0, 3'((i + j) % 8), 1'b1, 1'b1};
                default: return {20'(j + 7), 7'd0, 3'(i), 1'b0, 1'b1};
            endcase
        end
        return 32'h0;
    endfunction

    // Memory model: stalls acceptance every fifth cycle, answers after 1..3 cycles.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 5) != 3;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pte_at(paddr);
                pend <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            pend  <= 1'b1;
            paddr <= mem_req_addr;
            dly   <= cyc % 3;
            nreads <= nreads + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Walks one address and compares every result field with the spec model.
    task automatic walk(input logic [31:0] va);
        logic [31:0] p1;
        logic [31:0] p2;
        bit e_fault;
        bit e_lvl;
        bit e_large;
        logic [19:0] e_ppn;
        logic [2:0] e_perm;
        int e_reads;
        int r0;
        int t;
        bit got;
        // Expected outcome from R2-R8.
        p1 = pte_at(ROOT + {20'd0, va[31:22], 2'b00});
        e_fault = 0; e_lvl = 0; e_large = 0; e_ppn = '0; e_perm = '0; e_reads = 1;
        if (!p1[0]) begin
            e_fault = 1;
        end else if (p1[1]) begin
            e_large = 1; e_ppn = p1[31:12]; e_perm = p1[4:2];
        end else begin
            e_reads = 2;
            p2 = pte_at({p1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00});
            if (!p2[0] || !p2[1]) begin
                e_fault = 1; e_lvl = 1;
            end else begin
                e_ppn = p2[31:12]; e_perm = p2[4:2];
            end
        end
        @(negedge clk);
        r0 = nreads;
        miss_valid = 1'b1;
        miss_vaddr = va;
        @(negedge clk);
        // R10: busy walker refuses misses; keep offering a different address.
        chk(miss_ready == 1'b0, "R10", "miss_ready while busy", 32'(miss_ready), 32'd0);
        miss_vaddr = ~va;
        got = 0;
        for (t = 0; t < 60; t++) begin
            if (refill_valid || fault_valid) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
        miss_valid = 1'b0;
        chk(got, "R9", "walk result arrived", 32'(got), 32'd1);
        if (got) begin
            chk(fault_valid == e_fault, e_fault ? "R7" : "R6", "fault vs refill",
                32'(fault_valid), 32'(e_fault));
            chk(nreads - r0 == e_reads, e_large ? "R5" : "R3", "reads issued",
                32'(nreads - r0), 32'(e_reads));
            if (e_fault) begin
                chk(fault_level == e_lvl, e_lvl ? "R8" : "R7", "fault_level",
                    32'(fault_level), 32'(e_lvl));
                chk(fault_vaddr == va, "R11", "fault_vaddr", fault_vaddr, va);
            end else begin
                chk(refill_large == e_large, e_large ? "R5" : "R6", "refill_large",
                    32'(refill_large), 32'(e_large));
                chk(refill_ppn == e_ppn, "R4", "refill_ppn", 32'(refill_ppn), 32'(e_ppn));
                chk(refill_perm == e_perm, "R4", "refill_perm", 32'(refill_perm), 32'(e_perm));
                chk(refill_vpn == va[31:12], "R11", "refill_vpn", 32'(refill_vpn), 32'(va[31:12]));
            end
            @(negedge clk);
            chk(!refill_valid && !fault_valid, "R11", "pulse width one cycle",
                32'({refill_valid, fault_valid}), 32'd0);
        end
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(miss_ready == 1'b1, "R1", "miss_ready after reset", 32'(miss_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R1", "no read after reset", 32'(mem_req_valid), 32'd0);
        chk(!refill_valid && !fault_valid, "R1", "no pulse after reset",
            32'({refill_valid, fault_valid}), 32'd0);
        // R2 R5 R7: every first-level index, second level varied.
        for (int i = 0; i < 1024; i++) begin
            walk({10'(i), 10'((i * 7 + 3) % 1024), 12'(i * 37)});
        end
        // R3 R6 R8: every second-level index under one pointer entry.
        for (int j = 0; j < 1024; j++) begin
            walk({10'd2, 10'(j), 12'(j * 11)});
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule